// File: doc/BRIEF.md
# Four-Slot Memory Bank Mapper

The mapper sits between a 16-bit CPU and a 20-bit physical memory space holding three kinds of device: ROM, internal RAM and removable card memory. The CPU space is cut into four 16 KB windows. Each window has its own 8-bit mapping register on the I/O bus. The low six bits of that register name a 16 KB bank, and the two top bits pick the device. The window offset passes through unchanged, so every access reaches exactly one device at a 20-bit address.

Card memory may be slow. A write-only control register holds a wait enable, which is set on reset. While it is set, every card access asserts a wait request for exactly one extra cycle. A small state machine with two states sets this timing. In `ST_IDLE` it accepts a new access. The transition `T_ENTER_STALL` (IDLE to STALL) is taken when a memory request targets the card while waits are enabled, and it raises the wait request for that cycle. In `ST_STALL` the access completes without waiting. The transition `T_RELEASE` (STALL to IDLE) is always taken on the next clock. In every other case the machine stays in IDLE (`T_HOLD`). A memory request is held high for the whole access, and an access completes in the first cycle that has the request high and the wait request low.

Top module: `bank_mapper`

## Requirements
- R1: After reset all four mapping registers read 0x00, so every window maps to ROM bank 0. The wait enable is also set after reset.
- R2: CPU address bits 15:14 pick the window register. The registers for windows 0 to 3 sit at I/O ports 0x10, 0x11, 0x12 and 0x13.
- R3: The physical address is formed as `{reg[5:0], cpu_addr[13:0]}`.
- R4: Register bit 7 set selects card memory, even when bit 6 is also set. Bit 6 set alone selects internal RAM. Neither bit set selects ROM. Exactly one of the three selects is high at any time.
- R5: A write to a window port changes that register from the next cycle on. While `io_rd` is high on a window port, `io_rdata` shows that register in the same cycle. Any other port, the wait port included, reads as 0x00.
- R6: A write to port 0x20 loads the wait enable from data bit 7. The other data bits and the window registers are left unchanged.
- R7: With waits enabled, a card access raises `wait_req` in its first cycle only. A held request then completes in the second cycle, and back-to-back card accesses each wait once.
- R8: `wait_req` never rises for ROM or internal RAM accesses. It also never rises for card accesses while the wait enable is clear.
- R9: A write to any port other than 0x10 to 0x13 or 0x20 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU memory address |
| mem_req | input | 1 | Memory access in progress, held until the access completes |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_port | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, combinational |
| phys_addr | output | 20 | Mapped physical address |
| sel_rom | output | 1 | ROM selected |
| sel_ram | output | 1 | Internal RAM selected |
| sel_card | output | 1 | Card memory selected |
| wait_req | output | 1 | Wait request for the current access |

## Verification
Some properties are checked by assertions on every cycle. Exactly one device select is high. A wait request is never followed by another and only appears on an enabled card access. Every register write lands in the next cycle. Other behaviour needs the bench scenarios. These cover the reset contents, the bank arithmetic for chosen values such as 0x42 and 0xC5, and card priority when both device bits are set. They also cover write-only bits being ignored, foreign ports leaving the registers alone, and back-to-back card accesses each waiting once. A cycle-accurate reference model then compares every output on every clock.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
    typedef enum logic [1:0] {
        DEV_ROM  = 2'd0,
        DEV_IRAM = 2'd1,
        DEV_CARD = 2'd2
    } dev_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_STALL = 1'b1
    } wst_e;
endpackage

// File: rtl/bank_slot_regs.sv
module bank_slot_regs #(
    parameter int N_SLOTS   = 4,
    parameter int REG_W     = 8,
    parameter int PORT_W    = 8,
    parameter int MAP_BASE  = 'h10,
    parameter int WAIT_PORT = 'h20,
    parameter int WAIT_BIT  = 7
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           io_wr,
    input  logic                           io_rd,
    input  logic [PORT_W-1:0]              io_port,
    input  logic [REG_W-1:0]               io_wdata,
    output logic [N_SLOTS-1:0][REG_W-1:0]  slot_q,
    output logic                           wait_en,
    output logic [REG_W-1:0]               io_rdata
);
    localparam logic [PORT_W-1:0] WAIT_ADDR = PORT_W'(WAIT_PORT);

    logic [N_SLOTS-1:0] hit;

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
        localparam logic [PORT_W-1:0] SLOT_ADDR = PORT_W'(MAP_BASE + i);
        assign hit[i] = (io_port == SLOT_ADDR);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[i] <= '0;
            else if (io_wr && hit[i])
                slot_q[i] <= io_wdata;
        end

        p_slot_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (io_wr && io_port == SLOT_ADDR) |=> (slot_q[i] == $past(io_wdata)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wait_en <= 1'b1;
        else if (io_wr && io_port == WAIT_ADDR)
            wait_en <= io_wdata[WAIT_BIT];
    end

    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            for (int i = 0; i < N_SLOTS; i++) begin
                if (hit[i])
                    io_rdata = slot_q[i];
            end
        end
    end

    p_wait_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_port == WAIT_ADDR) |=> (wait_en == $past(io_wdata[WAIT_BIT])));

    p_slots_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_wr || hit == '0) |=> $stable(slot_q));
endmodule

// File: rtl/bank_decode.sv
module bank_decode
    import bank_map_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 14,
    parameter int BANK_W = 6,
    parameter int REG_W  = 8,
    localparam int SLOT_BITS = ADDR_W - PAGE_W,
    localparam int N_SLOTS   = 1 << SLOT_BITS,
    localparam int PHYS_W    = PAGE_W + BANK_W
) (
    input  logic [ADDR_W-1:0]              cpu_addr,
    input  logic [N_SLOTS-1:0][REG_W-1:0]  slot_q,
    output logic [PHYS_W-1:0]              phys_addr,
    output dev_e                           dev
);
    localparam int CARD_BIT = REG_W - 1;
    localparam int IRAM_BIT = REG_W - 2;

    logic [SLOT_BITS-1:0] idx;
    logic [REG_W-1:0]     cur;

    always_comb begin
        idx       = cpu_addr[ADDR_W-1 -: SLOT_BITS];
        cur       = slot_q[idx];
        phys_addr = {cur[BANK_W-1:0], cpu_addr[PAGE_W-1:0]};
        if (cur[CARD_BIT])
            dev = DEV_CARD;
        else if (cur[IRAM_BIT])
            dev = DEV_IRAM;
        else
            dev = DEV_ROM;
    end
endmodule

// File: rtl/bank_wait_fsm.sv
module bank_wait_fsm
    import bank_map_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mem_req,
    input  logic is_card,
    input  logic wait_en,
    output logic wait_req
);
    wst_e state, state_nx;
    logic want_wait;

    assign want_wait = mem_req && is_card && wait_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        wait_req = 1'b0;
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (want_wait) begin
                    wait_req = 1'b1;
                    state_nx = ST_STALL;
                end
            end
            ST_STALL: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    p_wait_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wait_req |=> !wait_req);

    p_wait_card_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wait_req |-> (is_card && wait_en && mem_req));

    p_stall_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STALL) |=> (state == ST_IDLE));
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import bank_map_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int PAGE_W    = 14,
    parameter int BANK_W    = 6,
    parameter int REG_W     = 8,
    parameter int PORT_W    = 8,
    parameter int MAP_BASE  = 'h10,
    parameter int WAIT_PORT = 'h20,
    parameter int WAIT_BIT  = 7,
    localparam int SLOT_BITS = ADDR_W - PAGE_W,
    localparam int N_SLOTS   = 1 << SLOT_BITS,
    localparam int PHYS_W    = PAGE_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              mem_req,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [PORT_W-1:0] io_port,
    input  logic [REG_W-1:0]  io_wdata,
    output logic [REG_W-1:0]  io_rdata,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              sel_rom,
    output logic              sel_ram,
    output logic              sel_card,
    output logic              wait_req
);
    logic [N_SLOTS-1:0][REG_W-1:0] slot_q;
    logic wait_en;
    dev_e dev;

    bank_slot_regs #(
        .N_SLOTS(N_SLOTS), .REG_W(REG_W), .PORT_W(PORT_W),
        .MAP_BASE(MAP_BASE), .WAIT_PORT(WAIT_PORT), .WAIT_BIT(WAIT_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
        .io_port(io_port), .io_wdata(io_wdata),
        .slot_q(slot_q), .wait_en(wait_en), .io_rdata(io_rdata)
    );

    bank_decode #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BANK_W(BANK_W), .REG_W(REG_W)
    ) u_dec (
        .cpu_addr(cpu_addr), .slot_q(slot_q),
        .phys_addr(phys_addr), .dev(dev)
    );

    assign sel_rom  = (dev == DEV_ROM);
    assign sel_ram  = (dev == DEV_IRAM);
    assign sel_card = (dev == DEV_CARD);

    bank_wait_fsm u_wait (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req),
        .is_card(sel_card), .wait_en(wait_en), .wait_req(wait_req)
    );

    p_one_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sel_rom, sel_ram, sel_card}) == 1);

    p_offset_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[PAGE_W-1:0] == cpu_addr[PAGE_W-1:0]);
endmodule

// File: tb/bank_mapper_tb.sv
module bank_mapper_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        mem_req = 1'b0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_port = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [19:0] phys_addr;
    logic        sel_rom, sel_ram, sel_card, wait_req;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    bank_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mem_req(mem_req),
        .io_wr(io_wr), .io_rd(io_rd), .io_port(io_port), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .phys_addr(phys_addr), .sel_rom(sel_rom),
        .sel_ram(sel_ram), .sel_card(sel_card), .wait_req(wait_req)
    );

    always #5 clk = ~clk;

    // Behavioural reference model
    int m_slot [4];
    int m_wait_en;
    int m_stall;

    function automatic int cur_reg();
        return m_slot[cpu_addr / 16384];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_slot[k]) m_slot[k] = 0;
            m_wait_en = 1;
            m_stall = 0;
        end else begin
            int r;
            r = cur_reg();
            if (m_stall == 0 && mem_req && r >= 128 && m_wait_en == 1)
                m_stall = 1;
            else
                m_stall = 0;
            if (io_wr) begin
                if (io_port >= 8'h10 && io_port <= 8'h13)
                    m_slot[io_port - 8'h10] = io_wdata;
                else if (io_port == 8'h20)
                    m_wait_en = io_wdata / 128;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int r, exp_rd, exp_wait;
            r = cur_reg();
            chk("R3 phys_addr", phys_addr, (r % 64) * 16384 + cpu_addr % 16384);
            chk("R4 selects", {sel_rom, sel_ram, sel_card},
                r >= 128 ? 3'b001 : (r >= 64 ? 3'b010 : 3'b100));
            exp_wait = (m_stall == 0 && mem_req && r >= 128 && m_wait_en == 1) ? 1 : 0;
            chk("R7 wait_req", wait_req, exp_wait);
            exp_rd = (io_rd && io_port >= 8'h10 && io_port <= 8'h13) ? m_slot[io_port - 8'h10] : 0;
            chk("R5 io_rdata", io_rdata, exp_rd);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic io_write(input logic [7:0] p, input logic [7:0] d);
        @(posedge clk); #1;
        io_wr = 1; io_port = p; io_wdata = d;
        @(posedge clk); #1;
        io_wr = 0; io_port = 8'h00;
    endtask

    task automatic io_read(input logic [7:0] p, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        io_rd = 1; io_port = p;
        @(negedge clk);
        chk(tag, io_rdata, exp);
        @(posedge clk); #1;
        io_rd = 0; io_port = 8'h00;
    endtask

    // Hold a request for two cycles and check the wait pattern
    task automatic access2(input logic [15:0] a, input bit w0, input string tag);
        @(posedge clk); #1;
        mem_req = 1; cpu_addr = a;
        @(negedge clk);
        chk(tag, wait_req, w0);
        @(posedge clk); #1;
        @(negedge clk);
        chk(tag, wait_req, 0);
        @(posedge clk); #1;
        mem_req = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset contents
        for (int s = 0; s < 4; s++) io_read(8'h10 + 8'(s), 8'h00, "R1 reset slot");
        @(posedge clk); #1 cpu_addr = 16'hC123;
        @(negedge clk);
        chk("R1 reset maps to rom", {sel_rom, phys_addr}, {1'b1, 20'h00123});

        // R2/R3/R4: 0x42 into window 1 -> internal RAM bank 2
        io_write(8'h11, 8'h42);
        io_read(8'h11, 8'h42, "R5 readback");
        @(posedge clk); #1 cpu_addr = 16'h4123;
        @(negedge clk);
        chk("R2 window1 phys", phys_addr, 20'h08123);
        chk("R4 iram select", {sel_rom, sel_ram, sel_card}, 3'b010);
        @(posedge clk); #1 cpu_addr = 16'h0123;
        @(negedge clk);
        chk("R2 window0 untouched", phys_addr, 20'h00123);

        // R4: both type bits set -> card, bank 5
        io_write(8'h12, 8'hC5);
        @(posedge clk); #1 cpu_addr = 16'hBFFF;
        @(negedge clk);
        chk("R4 card priority", {sel_card, phys_addr}, {1'b1, 20'h17FFF});

        // R1/R7: waits enabled from reset, card access waits one cycle
        access2(16'h8010, 1, "R7 card wait first");
        // R7: back-to-back card accesses each wait once
        @(posedge clk); #1 mem_req = 1; cpu_addr = 16'h8000;
        @(negedge clk); chk("R7 b2b first", wait_req, 1);
        @(posedge clk); #1; @(negedge clk); chk("R7 b2b done", wait_req, 0);
        @(posedge clk); #1 cpu_addr = 16'h8004;
        @(negedge clk); chk("R7 b2b second", wait_req, 1);
        @(posedge clk); #1 mem_req = 0;

        // R8: ROM and RAM never wait
        access2(16'h4000, 0, "R8 ram no wait");
        access2(16'hC000, 0, "R8 rom no wait");

        // R6: only bit 7 matters; 0x7F disables waits
        io_write(8'h20, 8'h7F);
        access2(16'h8000, 0, "R6 wait disabled");
        io_read(8'h20, 8'h00, "R5 wait port reads zero");
        io_write(8'h20, 8'h80);
        access2(16'h8000, 1, "R6 wait re-enabled");

        // R9: foreign ports leave registers unchanged
        io_write(8'h14, 8'hFF);
        io_write(8'h0F, 8'hFF);
        io_write(8'h30, 8'h00);
        io_read(8'h10, 8'h00, "R9 slot0 kept");
        io_read(8'h11, 8'h42, "R9 slot1 kept");
        io_read(8'h12, 8'hC5, "R9 slot2 kept");
        io_read(8'h13, 8'h00, "R9 slot3 kept");
        access2(16'h8000, 1, "R9 wait kept");

        // Sweep every window with distinct values
        for (int s = 0; s < 4; s++) io_write(8'h10 + 8'(s), 8'(8'h81 + s * 8'h21));
        for (int s = 0; s < 4; s++) begin
            @(posedge clk); #1 cpu_addr = 16'(s * 16384 + 16'h0AB);
            @(negedge clk);
        end

        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule